// File: doc/BRIEF.md
# Per-Block Flash Lock Controller

This block guards a 4 Mbit flash array that is split into eight 64 KB blocks. It keeps a small lock register for each block. It combines those registers with two active-low hardware protect pins to decide, one cycle after each request, whether an array read, program or erase may go ahead. Software sets and reads the lock registers through a simple indexed configuration port. The flash core reports through one input whether a program or erase is running or suspended.

Each lock register has three live bits: write lock in bit 0, lock-down in bit 1 and read lock in bit 2. Once lock-down is set, the register cannot be changed until reset. One pin guards only the top block (block 7) and the other guards blocks 0 to 6, and both overrule the registers for program and erase. The write-lock bits and the pin levels that judge program and erase are frozen for as long as the core reports an operation in flight.

Top module: `flash_lock_ctrl`

## Requirements
- R1: After reset every lock register reads 01h (write locked), and `acc_ok` and `prot_err` are low.
- R2: A configuration write to an unlocked register stores bits 2:0 of `cfg_wdata`. `cfg_rdata` always shows the register chosen by `cfg_idx` in bits 2:0, with bits 7:3 reading 0 whatever was written.
- R3: A read request (`req_op` = 00) to a block whose bit 2 is set is refused: `acc_ok` stays low and `rd_data` becomes FFh. A permitted read raises `acc_ok` for one cycle and presents the `array_rdata` sampled with the request. Both outcomes appear in the cycle after the request.
- R4: A program (`req_op` = 01) or erase (`req_op` = 10) to a block whose bit 0 is set is refused with a one-cycle `prot_err` pulse in the cycle after the request. A permitted one gives a one-cycle `acc_ok` pulse instead. The two pulses are never high together.
- R5: When bit 1 (lock-down) of a register is set, later configuration writes to it are ignored, including writes that try to clear lock-down. Only reset returns it to 01h.
- R6: While `top_lock_n` is low, program and erase to block 7 are refused whatever its register holds. Blocks 0 to 6 are not affected by this pin.
- R7: While `wr_prot_n` is low, program and erase to blocks 0 to 6 are refused whatever their registers hold. Block 7 is not affected by this pin.
- R8: The protect pins have no effect on array reads or on configuration writes and reads.
- R9: While `core_busy` is high, program and erase are judged with the write-lock bits and pin levels held when it rose. Register and pin changes made in that time take effect for program and erase once `core_busy` falls.
- R10: The block targeted by a request is taken from `req_addr[18:16]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en | input | 1 | Write strobe for the lock register chosen by `cfg_idx` |
| cfg_idx | input | 3 | Lock register index, used for both write and read |
| cfg_wdata | input | 8 | Value to write |
| cfg_rdata | output | 8 | Contents of the selected lock register, bits 7:3 zero |
| req_valid | input | 1 | An access request is presented this cycle |
| req_op | input | 2 | 00 read, 01 program, 10 erase, 11 no action |
| req_addr | input | 19 | Array byte address |
| array_rdata | input | 8 | Array data for the address of a read request |
| top_lock_n | input | 1 | Low guards block 7 against program and erase |
| wr_prot_n | input | 1 | Low guards blocks 0 to 6 against program and erase |
| core_busy | input | 1 | A program or erase is running or suspended |
| acc_ok | output | 1 | One-cycle pulse: the previous request is allowed |
| prot_err | output | 1 | One-cycle pulse: the previous program or erase is refused |
| rd_data | output | 8 | Data of the last read request, FFh when refused |

## Verification
Programs and erases are sent to blocks under every mix of register write lock, each protect pin and lock-down. This separates a refusal caused by the register from one caused by the pin that owns that block, and shows that the other pin does nothing. Reads go to read-locked and open blocks while the pins are held low, so the read path is shown to ignore the pins. Lock-down is tried with writes that set bits, clear bits and touch reserved bits, and then with a second reset. A freeze sequence changes a lock register and a pin while `core_busy` is high, and checks the decision before and after `core_busy` falls.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_PROG  = 2'b01,
    OP_ERASE = 2'b10,
    OP_NONE  = 2'b11
  } acc_op_e;

  // live bits of one lock register
  localparam int LOCK_W  = 3;
  localparam int WL_BIT  = 0;
  localparam int LD_BIT  = 1;
  localparam int RL_BIT  = 2;
  localparam logic [LOCK_W-1:0] LOCK_RST = 3'b001;

endpackage

// File: rtl/lock_reg_bank.sv
module lock_reg_bank
  import flash_lock_pkg::*;
#(
  parameter int NUM_BLKS = 8,
  parameter int DATA_W   = 8,
  localparam int IDX_W   = $clog2(NUM_BLKS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           idx,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  output logic [NUM_BLKS-1:0]        wlock,
  output logic [NUM_BLKS-1:0]        rlock,
  output logic [NUM_BLKS*LOCK_W-1:0] lk_flat
);

  for (genvar gi = 0; gi < NUM_BLKS; gi++) begin : g_blk
    logic [LOCK_W-1:0] lk_q;
    logic [LOCK_W-1:0] lk_d;
    logic              upd_en;

    always_comb begin
      upd_en = wr_en && (idx == IDX_W'(gi)) && !lk_q[LD_BIT];
      lk_d   = wdata[LOCK_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lk_q <= LOCK_RST;
      else if (upd_en) lk_q <= lk_d;
    end

    assign wlock[gi]                   = lk_q[WL_BIT];
    assign rlock[gi]                   = lk_q[RL_BIT];
    assign lk_flat[gi*LOCK_W +: LOCK_W] = lk_q;
  end

  always_comb begin
    rdata              = '0;
    rdata[LOCK_W-1:0]  = lk_flat[idx*LOCK_W +: LOCK_W];
  end

endmodule

// File: rtl/prot_snapshot.sv
module prot_snapshot #(
  parameter int NUM_BLKS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                busy,
  input  logic [NUM_BLKS-1:0] live_wlock,
  input  logic                live_top_n,
  input  logic                live_wp_n,
  output logic [NUM_BLKS-1:0] eff_wlock,
  output logic                eff_top_n,
  output logic                eff_wp_n
);

  logic [NUM_BLKS-1:0] snap_wlock_q;
  logic                snap_top_q;
  logic                snap_wp_q;
  logic                cap_en;

  assign cap_en = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_wlock_q <= '1;
      snap_top_q   <= 1'b0;
      snap_wp_q    <= 1'b0;
    end else if (cap_en) begin
      snap_wlock_q <= live_wlock;
      snap_top_q   <= live_top_n;
      snap_wp_q    <= live_wp_n;
    end
  end

  always_comb begin
    if (busy) begin
      eff_wlock = snap_wlock_q;
      eff_top_n = snap_top_q;
      eff_wp_n  = snap_wp_q;
    end else begin
      eff_wlock = live_wlock;
      eff_top_n = live_top_n;
      eff_wp_n  = live_wp_n;
    end
  end

endmodule

// File: rtl/access_judge.sv
module access_judge
  import flash_lock_pkg::*;
#(
  parameter int NUM_BLKS = 8,
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 8,
  localparam int IDX_W   = $clog2(NUM_BLKS),
  localparam int TOP_BLK = NUM_BLKS - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [1:0]          req_op,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   array_rdata,
  input  logic [NUM_BLKS-1:0] rlock,
  input  logic [NUM_BLKS-1:0] eff_wlock,
  input  logic                eff_top_n,
  input  logic                eff_wp_n,
  output logic                acc_ok,
  output logic                prot_err,
  output logic [DATA_W-1:0]   rd_data
);

  acc_op_e           op;
  logic [IDX_W-1:0]  blk;
  logic              is_rd, is_wr, pin_hold, rd_ok, wr_ok;
  logic              ok_d, err_d;
  logic [DATA_W-1:0] rdata_d;
  logic              ok_q, err_q;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    op       = acc_op_e'(req_op);
    blk      = req_addr[ADDR_W-1 -: IDX_W];
    is_rd    = (op == OP_READ);
    is_wr    = (op == OP_PROG) || (op == OP_ERASE);
    pin_hold = (blk == IDX_W'(TOP_BLK)) ? !eff_top_n : !eff_wp_n;
    wr_ok    = !pin_hold && !eff_wlock[blk];
    rd_ok    = !rlock[blk];
    ok_d     = req_valid && ((is_rd && rd_ok) || (is_wr && wr_ok));
    err_d    = req_valid && is_wr && !wr_ok;
    rdata_d  = rdata_q;
    if (req_valid && is_rd) rdata_d = rd_ok ? array_rdata : '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '1;
    end else begin
      ok_q    <= ok_d;
      err_q   <= err_d;
      rdata_q <= rdata_d;
    end
  end

  assign acc_ok   = ok_q;
  assign prot_err = err_q;
  assign rd_data  = rdata_q;

endmodule

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl
  import flash_lock_pkg::*;
#(
  parameter int NUM_BLKS = 8,
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 8,
  localparam int IDX_W   = $clog2(NUM_BLKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] array_rdata,
  input  logic              top_lock_n,
  input  logic              wr_prot_n,
  input  logic              core_busy,
  output logic              acc_ok,
  output logic              prot_err,
  output logic [DATA_W-1:0] rd_data
);

  logic [1:0]                 rst_sync_q;
  logic                       rst_sync_n;
  logic [NUM_BLKS-1:0]        wlock, rlock, eff_wlock;
  logic [NUM_BLKS*LOCK_W-1:0] lk_flat;
  logic                       eff_top_n, eff_wp_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  lock_reg_bank #(.NUM_BLKS(NUM_BLKS), .DATA_W(DATA_W)) i_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (cfg_wr_en),
    .idx     (cfg_idx),
    .wdata   (cfg_wdata),
    .rdata   (cfg_rdata),
    .wlock   (wlock),
    .rlock   (rlock),
    .lk_flat (lk_flat)
  );

  prot_snapshot #(.NUM_BLKS(NUM_BLKS)) i_snap (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .busy       (core_busy),
    .live_wlock (wlock),
    .live_top_n (top_lock_n),
    .live_wp_n  (wr_prot_n),
    .eff_wlock  (eff_wlock),
    .eff_top_n  (eff_top_n),
    .eff_wp_n   (eff_wp_n)
  );

  access_judge #(.NUM_BLKS(NUM_BLKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_judge (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .req_addr    (req_addr),
    .array_rdata (array_rdata),
    .rlock       (rlock),
    .eff_wlock   (eff_wlock),
    .eff_top_n   (eff_top_n),
    .eff_wp_n    (eff_wp_n),
    .acc_ok      (acc_ok),
    .prot_err    (prot_err),
    .rd_data     (rd_data)
  );

endmodule

// File: rtl/flash_lock_chk.sv
module flash_lock_chk
  import flash_lock_pkg::*;
#(
  parameter int NUM_BLKS = 8,
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 8,
  localparam int IDX_W   = $clog2(NUM_BLKS),
  localparam int TOP_BLK = NUM_BLKS - 1
) (
  input logic                       clk,
  input logic                       rst_sync_n,
  input logic [DATA_W-1:0]          cfg_rdata,
  input logic                       req_valid,
  input logic [1:0]                 req_op,
  input logic [ADDR_W-1:0]          req_addr,
  input logic                       top_lock_n,
  input logic                       wr_prot_n,
  input logic                       core_busy,
  input logic                       acc_ok,
  input logic                       prot_err,
  input logic [DATA_W-1:0]          rd_data,
  input logic [NUM_BLKS*LOCK_W-1:0] lk_flat
);

  logic [IDX_W-1:0] blk;
  logic             is_wr, is_rd, rl_hit;

  always_comb begin
    blk    = req_addr[ADDR_W-1 -: IDX_W];
    is_rd  = (req_op == 2'b00);
    is_wr  = (req_op == 2'b01) || (req_op == 2'b10);
    rl_hit = lk_flat[int'(blk)*LOCK_W + RL_BIT];
  end

  // R4
  no_dual_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(acc_ok && prot_err));

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_rdata[DATA_W-1:LOCK_W] == '0);

  // R3
  rd_refuse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && is_rd && rl_hit) |=> (!acc_ok && rd_data == '1));

  // R8
  rd_no_err_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && is_rd) |=> !prot_err);

  // R7
  wp_pin_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && is_wr && !core_busy && !wr_prot_n && blk != IDX_W'(TOP_BLK)) |=> prot_err);

  // R6
  top_pin_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && is_wr && !core_busy && !top_lock_n && blk == IDX_W'(TOP_BLK)) |=> prot_err);

  for (genvar gi = 0; gi < NUM_BLKS; gi++) begin : g_ld
    // R5
    ldown_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      lk_flat[gi*LOCK_W + LD_BIT] |=> $stable(lk_flat[gi*LOCK_W +: LOCK_W]));
  end

endmodule

bind flash_lock_ctrl flash_lock_chk #(
  .NUM_BLKS (NUM_BLKS),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W)
) i_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .cfg_rdata  (cfg_rdata),
  .req_valid  (req_valid),
  .req_op     (req_op),
  .req_addr   (req_addr),
  .top_lock_n (top_lock_n),
  .wr_prot_n  (wr_prot_n),
  .core_busy  (core_busy),
  .acc_ok     (acc_ok),
  .prot_err   (prot_err),
  .rd_data    (rd_data),
  .lk_flat    (lk_flat)
);

// File: tb/test_flash_lock_ctrl.sv
`timescale 1ns/1ps
module test_flash_lock_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wr_en;
  logic [2:0] cfg_idx;
  logic [7:0] cfg_wdata, cfg_rdata;
  logic       req_valid;
  logic [1:0] req_op;
  logic [18:0] req_addr;
  logic [7:0] array_rdata;
  logic       top_lock_n, wr_prot_n, core_busy;
  logic       acc_ok, prot_err;
  logic [7:0] rd_data;

  always #2.5 clk = ~clk;

  flash_lock_ctrl i_flash_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_op(req_op), .req_addr(req_addr), .array_rdata(array_rdata),
    .top_lock_n(top_lock_n), .wr_prot_n(wr_prot_n), .core_busy(core_busy),
    .acc_ok(acc_ok), .prot_err(prot_err), .rd_data(rd_data)
  );

  typedef struct {
    logic       ok;
    logic       err;
    logic       is_rd;
    logic [7:0] data;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_run  = 0;
  int   n_fail = 0;
  logic done   = 1'b0;

  // reference state
  logic [2:0] m_lk [8];
  logic       m_snap_wl [8];
  logic       m_snap_top, m_snap_wp, m_busy;

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_lk[i] = 3'b001;
    m_busy = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [2:0] idx, input logic [7:0] val);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_idx = idx; cfg_wdata = val;
    @(posedge clk);
    if (!m_lk[idx][1]) m_lk[idx] = val[2:0];
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic cfg_check(input logic [2:0] idx, input string tag);
    @(negedge clk);
    cfg_idx = idx;
    #1;
    n_run++;
    if (cfg_rdata !== {5'b0, m_lk[idx]}) begin
      n_fail++;
      $display("FAIL %s: reg %0d actual %02h expected %02h", tag, idx, cfg_rdata, {5'b0, m_lk[idx]});
    end
  endtask

  task automatic set_pins(input logic top_n, input logic wp_n);
    @(negedge clk);
    top_lock_n = top_n; wr_prot_n = wp_n;
  endtask

  task automatic set_busy(input logic b);
    @(negedge clk);
    if (b) begin
      for (int i = 0; i < 8; i++) m_snap_wl[i] = m_lk[i][0];
      m_snap_top = top_lock_n;
      m_snap_wp  = wr_prot_n;
    end
    m_busy    = b;
    core_busy = b;
  endtask

  // driver: computes the expected outcome and queues it
  task automatic access(input logic [1:0] op, input logic [18:0] addr,
                        input logic [7:0] adata, input string tag);
    exp_t e;
    logic [2:0] blk;
    logic wl, tn, wn, hold;
    blk = addr[18:16];
    e.tag = tag; e.is_rd = (op == 2'b00); e.data = 8'hFF;
    if (op == 2'b00) begin
      e.ok = !m_lk[blk][2]; e.err = 1'b0;
      e.data = e.ok ? adata : 8'hFF;
    end else begin
      wl = m_busy ? m_snap_wl[blk] : m_lk[blk][0];
      tn = m_busy ? m_snap_top : top_lock_n;
      wn = m_busy ? m_snap_wp : wr_prot_n;
      hold = (blk == 3'd7) ? !tn : !wn;
      e.ok = !hold && !wl; e.err = !e.ok;
    end
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; array_rdata = adata;
    @(posedge clk);
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_run++;
      if (acc_ok !== e.ok || prot_err !== e.err || (e.is_rd && rd_data !== e.data)) begin
        n_fail++;
        $display("FAIL %s: ok/err/data actual %b/%b/%02h expected %b/%b/%02h",
                 e.tag, acc_ok, prot_err, rd_data, e.ok, e.err, e.data);
      end
    end else if (rst_n === 1'b1 && (acc_ok !== 1'b0 || prot_err !== 1'b0)) begin
      n_run++; n_fail++;
      $display("FAIL R4 idle pulse: ok/err actual %b/%b expected 0/0", acc_ok, prot_err);
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_idx = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_op = '0; req_addr = '0; array_rdata = '0;
    top_lock_n = 1'b1; wr_prot_n = 1'b1; core_busy = 1'b0;
    model_reset();
    do_reset();

    // R1 reset values and quiet outputs
    for (int i = 0; i < 8; i++) cfg_check(3'(i), "R1 reset value");
    n_run++;
    if (acc_ok !== 1'b0 || prot_err !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 outputs: actual %b/%b expected 0/0", acc_ok, prot_err);
    end

    // R4 write lock refuses program and erase; R10 block from addr[18:16]
    access(2'b01, 19'h3_1234, 8'h00, "R4 prog write-locked blk3");
    access(2'b10, 19'h0_0000, 8'h00, "R4 erase write-locked blk0");

    // R2 reserved bits dropped
    cfg_write(3'd3, 8'hF8);
    cfg_check(3'd3, "R2 reserved bits read zero");
    access(2'b01, 19'h3_FFFF, 8'h00, "R4 R10 prog unlocked blk3");
    access(2'b10, 19'h2_0000, 8'h00, "R10 erase blk2 still locked");

    // R3 read lock
    cfg_write(3'd2, 8'h04);
    cfg_check(3'd2, "R2 store read lock");
    access(2'b00, 19'h2_0010, 8'h5A, "R3 read refused blk2");
    access(2'b00, 19'h3_0010, 8'hA5, "R3 read allowed blk3");

    // R7 / R8 write-protect pin
    cfg_write(3'd7, 8'h00);
    cfg_write(3'd6, 8'h00);
    set_pins(1'b1, 1'b0);
    access(2'b01, 19'h3_0000, 8'h00, "R7 wp blocks blk3");
    access(2'b10, 19'h6_8000, 8'h00, "R7 wp blocks blk6");
    access(2'b01, 19'h7_0000, 8'h00, "R7 wp leaves blk7");
    access(2'b00, 19'h3_0004, 8'h3C, "R8 read ignores wp");
    cfg_write(3'd1, 8'h00);
    cfg_check(3'd1, "R8 cfg write under wp");

    // R6 top-block pin
    set_pins(1'b0, 1'b1);
    access(2'b10, 19'h7_FFFF, 8'h00, "R6 top pin blocks blk7");
    access(2'b01, 19'h6_0000, 8'h00, "R6 top pin leaves blk6");
    access(2'b00, 19'h7_0001, 8'hC3, "R8 read blk7 under top pin");
    set_pins(1'b1, 1'b1);

    // R5 lock down
    cfg_write(3'd5, 8'h03);
    cfg_write(3'd5, 8'h00);
    cfg_check(3'd5, "R5 lock-down ignores clear");
    access(2'b01, 19'h5_0000, 8'h00, "R5 locked-down write lock");
    cfg_write(3'd4, 8'h02);
    cfg_write(3'd4, 8'h05);
    cfg_check(3'd4, "R5 lock-down ignores set");
    access(2'b10, 19'h4_0000, 8'h00, "R5 locked-down open block");
    access(2'b00, 19'h4_0000, 8'h77, "R5 read open locked-down");

    // R9 freeze while busy
    set_busy(1'b1);
    cfg_write(3'd1, 8'h01);
    cfg_check(3'd1, "R9 register updates while busy");
    set_pins(1'b0, 1'b0);
    access(2'b01, 19'h1_0000, 8'h00, "R9 frozen lock and pins");
    access(2'b01, 19'h7_0000, 8'h00, "R9 frozen top pin");
    set_busy(1'b0);
    access(2'b01, 19'h1_0000, 8'h00, "R9 after busy falls");
    set_pins(1'b1, 1'b1);
    access(2'b01, 19'h1_0000, 8'h00, "R9 new write lock live");

    // R5 reset clears lock down
    do_reset();
    cfg_check(3'd5, "R5 reset clears lock-down");
    cfg_write(3'd5, 8'h00);
    cfg_check(3'd5, "R5 writable after reset");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule